// File: doc/BRIEF.md
# Shared Address Translation Buffer

This block is a fully associative translation buffer. It maps a virtual page number, qualified by an address space identifier (ASID), to a physical page number and a set of page attributes. Each entry carries its own page size, and a shared flag lets a page match under any ASID. The same entry array serves two lookup paths. The data path translates a full virtual address into a physical address. The refill path answers a separate instruction-side buffer that has missed, and returns the complete tag and data of the matching entry so that the requester can copy them.

Software fills entries through a write port, using records it has read from a translation table in external memory. The block never walks that table itself. A global mode flag selects single-address-space operation. In that mode the ASID takes no part in matching, and the write port refuses to create a second valid entry that has the same page number but a different ASID. Each lookup path reports a hit, a miss or a multiple hit. A hit comes with the translation and the protection bits; what to do with them is left to the requester.

Top module: `shared_tlb`

## Requirements
- R1: A synchronous reset, or a one-cycle pulse on `flush`, clears the valid bit of every entry in that same cycle. From the next cycle on, every lookup misses.
- R2: A write on the write port updates entry `w_idx` at the clock edge. A lookup issued in the same cycle as the write sees the old contents, and a lookup in any later cycle sees the new contents.
- R3: An entry matches when it is valid and its page number equals the looked-up page number on the bits that its page size compares. Outside single-address-space mode, its shared bit must also be set or its ASID must equal `cur_asid`.
- R4: When `svm_mode` is 1, an entry matches regardless of its ASID.
- R5: The size code in data bits [11:10] selects the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. The lowest 0, 2, 6 or 10 bits of the page number are left out of the compare. Those same bits of the physical page number are replaced by the matching virtual address bits, and virtual bits [9:0] always pass through unchanged.
- R6: When more than one entry matches, the port raises its multi-hit output, leaves its hit output low, and drives zero on its address, tag and data outputs.
- R7: Each lookup port registers its result. The done output is high exactly one cycle after the request and low otherwise. Hit, multi-hit, address and data outputs are zero in any cycle without a response.
- R8: A refill hit returns the matching entry's tag on `i_tag`, laid out as ASID [30:23], page number [22:1] and valid [0], and its data word on `i_entry`.
- R9: When `svm_mode` is 1, a valid write whose page number equals that of another valid entry with a different ASID is dropped. The entry is left untouched, and `w_reject` pulses high in the following cycle. Every other write clears `w_reject`.
- R10: The data word is laid out as physical page number [30:12], size [11:10], shared [9], cacheable [8], protection [7:6], dirty [5], write-through [4], space attribute [3:1] and timing control [0]. The data port returns it unchanged on `d_entry` whenever it hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| svm_mode | input | 1 | Single-address-space mode |
| cur_asid | input | 8 | Current address space identifier |
| w_en | input | 1 | Write strobe |
| w_idx | input | log2(ENTRIES) (6) | Entry index to write |
| w_valid | input | 1 | Valid bit to store |
| w_asid | input | 8 | ASID to store |
| w_vpn | input | 22 | Virtual page number to store |
| w_data | input | 31 | Data word to store (R10 layout) |
| w_reject | output | 1 | Previous write was refused (R9) |
| d_req | input | 1 | Data translation request |
| d_vaddr | input | 32 | Virtual address to translate |
| d_done | output | 1 | Data response valid |
| d_hit | output | 1 | Single hit |
| d_multi | output | 1 | Multiple hit |
| d_paddr | output | 29 | Physical address |
| d_entry | output | 31 | Data word of the hit entry |
| i_req | input | 1 | Refill request |
| i_vpn | input | 22 | Page number to look up for refill |
| i_done | output | 1 | Refill response valid |
| i_hit | output | 1 | Single hit |
| i_multi | output | 1 | Multiple hit |
| i_tag | output | 31 | Tag of the hit entry |
| i_entry | output | 31 | Data word of the hit entry |

## Verification
The bench runs every page size against a set of addresses on and around the page boundaries. A mask off by one bit shows up either as a hit on the wrong page or as a physical address with the wrong low page bits. It flips the shared bit, the current ASID and the single-address-space mode, and expects a miss or a hit that it works out arithmetically. It sets up two overlapping entries, where a design that picked one of them would report a hit in place of a multi-hit. It probes write ordering with a lookup in the same cycle as the write, which a design that forwarded the new entry would answer with a hit. It also attempts a conflicting write in single-address-space mode; a design that accepted that write would answer the next lookup with a multi-hit.

// File: rtl/shared_tlb_pkg.sv
package shared_tlb_pkg;
  localparam int ASID_W = 8;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;
  localparam int OFS_W  = 10;
  localparam int VA_W   = VPN_W + OFS_W;
  localparam int PA_W   = PPN_W + OFS_W;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic              vld;
  } tag_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       size;
    logic             shared;
    logic             cacheable;
    logic [1:0]       prot;
    logic             dirty;
    logic             wthru;
    logic [2:0]       space;
    logic             timing;
  } pdata_t;

  localparam int TAG_W  = $bits(tag_t);
  localparam int DATA_W = $bits(pdata_t);

  // Page-number bits ignored by the compare for each size code.
  function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
    int unsigned sh;
    case (sz)
      2'd0:    sh = 0;
      2'd1:    sh = 2;
      2'd2:    sh = 6;
      default: sh = 10;
    endcase
    return VPN_W'((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store import shared_tlb_pkg::*; #(
  parameter int ENTRIES = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       svm_mode,
  input  logic                       w_en,
  input  logic [$clog2(ENTRIES)-1:0] w_idx,
  input  tag_t                       w_tag,
  input  pdata_t                     w_data,
  output logic                       w_reject,
  output tag_t   [ENTRIES-1:0]       tags,
  output pdata_t [ENTRIES-1:0]       datas
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  pdata_t             data_q [ENTRIES];
  logic [ENTRIES-1:0] clash;
  logic               blocked;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign tags[g]  = '{asid: asid_q[g], vpn: vpn_q[g], vld: vld_q[g]};
    assign datas[g] = data_q[g];
    assign clash[g] = vld_q[g] && (w_idx != IDX_W'(g)) &&
                      (vpn_q[g] == w_tag.vpn) && (asid_q[g] != w_tag.asid);
  end

  assign blocked = w_en && w_tag.vld && svm_mode && (|clash);

  // Tag and data fields: no reset, written only through the port.
  always_ff @(posedge clk) begin
    if (w_en && !blocked) begin
      asid_q[w_idx] <= w_tag.asid;
      vpn_q[w_idx]  <= w_tag.vpn;
      data_q[w_idx] <= w_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)
      vld_q <= '0;
    else if (w_en && !blocked)
      vld_q[w_idx] <= w_tag.vld;
  end

  always_ff @(posedge clk) begin
    if (rst) w_reject <= 1'b0;
    else     w_reject <= blocked;
  end

  a_r1_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));
  a_r9_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    (blocked && !flush) |=> ($stable(vld_q) && w_reject));
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (w_en && !blocked && !flush) |=> (vld_q[$past(w_idx)] == $past(w_tag.vld)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match import shared_tlb_pkg::*; #(
  parameter int ENTRIES = 64
) (
  input  tag_t [ENTRIES-1:0]       tags,
  input  logic [ENTRIES-1:0][1:0]  sizes,
  input  logic [ENTRIES-1:0]       shared,
  input  logic                     svm_mode,
  input  logic [ASID_W-1:0]        cur_asid,
  input  logic [VPN_W-1:0]         vpn,
  output logic [ENTRIES-1:0]       hits
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] care;
    logic             page_eq;
    logic             space_ok;
    assign care     = ~size_mask(sizes[g]);
    assign page_eq  = ((tags[g].vpn ^ vpn) & care) == '0;
    assign space_ok = svm_mode || shared[g] || (tags[g].asid == cur_asid);
    assign hits[g]  = tags[g].vld && page_eq && space_ok;
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 64
) (
  input  logic [ENTRIES-1:0]         hits,
  output logic                       one,
  output logic                       multi,
  output logic [$clog2(ENTRIES)-1:0] idx
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    idx = '0;
    cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hits[i]) begin
        idx = idx | IDX_W'(i);
        cnt = cnt + CNT_W'(1);
      end
    end
  end

  assign one   = (cnt == CNT_W'(1));
  assign multi = (cnt > CNT_W'(1));
endmodule

// File: rtl/shared_tlb.sv
module shared_tlb import shared_tlb_pkg::*; #(
  parameter int ENTRIES = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       svm_mode,
  input  logic [ASID_W-1:0]          cur_asid,
  input  logic                       w_en,
  input  logic [$clog2(ENTRIES)-1:0] w_idx,
  input  logic                       w_valid,
  input  logic [ASID_W-1:0]          w_asid,
  input  logic [VPN_W-1:0]           w_vpn,
  input  logic [DATA_W-1:0]          w_data,
  output logic                       w_reject,
  input  logic                       d_req,
  input  logic [VA_W-1:0]            d_vaddr,
  output logic                       d_done,
  output logic                       d_hit,
  output logic                       d_multi,
  output logic [PA_W-1:0]            d_paddr,
  output logic [DATA_W-1:0]          d_entry,
  input  logic                       i_req,
  input  logic [VPN_W-1:0]           i_vpn,
  output logic                       i_done,
  output logic                       i_hit,
  output logic                       i_multi,
  output logic [TAG_W-1:0]           i_tag,
  output logic [DATA_W-1:0]          i_entry
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PORTS = 2;

  tag_t   [ENTRIES-1:0]      tags;
  pdata_t [ENTRIES-1:0]      datas;
  logic   [ENTRIES-1:0][1:0] size_v;
  logic   [ENTRIES-1:0]      shr_v;
  tag_t                      w_tag;

  assign w_tag = '{asid: w_asid, vpn: w_vpn, vld: w_valid};

  tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .svm_mode (svm_mode),
    .w_en     (w_en),
    .w_idx    (w_idx),
    .w_tag    (w_tag),
    .w_data   (w_data),
    .w_reject (w_reject),
    .tags     (tags),
    .datas    (datas)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_attr
    assign size_v[g] = datas[g].size;
    assign shr_v[g]  = datas[g].shared;
  end

  // Port 0 serves data translation, port 1 serves refill.
  logic [PORTS-1:0][VPN_W-1:0] look_vpn;
  logic [PORTS-1:0]            p_one;
  logic [PORTS-1:0]            p_multi;
  logic [PORTS-1:0][IDX_W-1:0] p_idx;

  assign look_vpn[0] = d_vaddr[VA_W-1:OFS_W];
  assign look_vpn[1] = i_vpn;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [ENTRIES-1:0] hits;
    tlb_match #(.ENTRIES(ENTRIES)) u_match (
      .tags     (tags),
      .sizes    (size_v),
      .shared   (shr_v),
      .svm_mode (svm_mode),
      .cur_asid (cur_asid),
      .vpn      (look_vpn[p]),
      .hits     (hits)
    );
    tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
      .hits  (hits),
      .one   (p_one[p]),
      .multi (p_multi[p]),
      .idx   (p_idx[p])
    );
  end

  pdata_t           d_sel;
  logic [PPN_W-1:0] d_keep;
  logic [PA_W-1:0]  d_phys;

  assign d_sel  = datas[p_idx[0]];
  assign d_keep = PPN_W'(size_mask(d_sel.size));
  assign d_phys = {(d_sel.ppn & ~d_keep) | (d_vaddr[PA_W-1:OFS_W] & d_keep),
                   d_vaddr[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      d_done  <= 1'b0;
      d_hit   <= 1'b0;
      d_multi <= 1'b0;
      d_paddr <= '0;
      d_entry <= '0;
      i_done  <= 1'b0;
      i_hit   <= 1'b0;
      i_multi <= 1'b0;
      i_tag   <= '0;
      i_entry <= '0;
    end else begin
      d_done  <= d_req;
      d_hit   <= d_req && p_one[0];
      d_multi <= d_req && p_multi[0];
      d_paddr <= (d_req && p_one[0]) ? d_phys : '0;
      d_entry <= (d_req && p_one[0]) ? d_sel  : '0;
      i_done  <= i_req;
      i_hit   <= i_req && p_one[1];
      i_multi <= i_req && p_multi[1];
      i_tag   <= (i_req && p_one[1]) ? tags[p_idx[1]]  : '0;
      i_entry <= (i_req && p_one[1]) ? datas[p_idx[1]] : '0;
    end
  end

  a_r7_done_follows: assert property (@(posedge clk) disable iff (rst)
    d_req |=> d_done);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !d_req |=> (!d_done && !d_hit && !d_multi));
  a_r6_multi_excl: assert property (@(posedge clk) disable iff (rst)
    d_multi |-> (!d_hit && d_paddr == '0));
  a_r8_refill_follows: assert property (@(posedge clk) disable iff (rst)
    i_req |=> i_done);
  a_r6_refill_excl: assert property (@(posedge clk) disable iff (rst)
    i_multi |-> (!i_hit && i_tag == '0));
endmodule

// File: tb/shared_tlb_test.sv
`timescale 1ns/1ps
module shared_tlb_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0, svm_mode = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic        w_en = 1'b0, w_valid = 1'b0;
  logic [2:0]  w_idx = '0;
  logic [7:0]  w_asid = '0;
  logic [21:0] w_vpn = '0;
  logic [30:0] w_data = '0;
  logic        w_reject;
  logic        d_req = 1'b0;
  logic [31:0] d_vaddr = '0;
  logic        d_done, d_hit, d_multi;
  logic [28:0] d_paddr;
  logic [30:0] d_entry;
  logic        i_req = 1'b0;
  logic [21:0] i_vpn = '0;
  logic        i_done, i_hit, i_multi;
  logic [30:0] i_tag, i_entry;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shared_tlb #(.ENTRIES(N)) uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] mkdata(input logic [18:0] ppn, input logic [1:0] sz, input logic sh);
    return {ppn, sz, sh, 1'b1, 2'b10, 1'b0, 1'b1, 3'b101, 1'b0};
  endfunction

  function automatic logic [21:0] mask_of(input logic [1:0] sz);
    return (sz == 0) ? 22'h0 : (sz == 1) ? 22'h3 : (sz == 2) ? 22'h3F : 22'h3FF;
  endfunction

  function automatic logic [28:0] exp_pa(input logic [18:0] ppn, input logic [1:0] sz, input logic [31:0] va);
    logic [18:0] m;
    m = mask_of(sz)[18:0];
    return {(ppn & ~m) | (va[28:10] & m), va[9:0]};
  endfunction

  task automatic wr(input logic [2:0] idx, input logic v, input logic [7:0] asid,
                    input logic [21:0] vpn, input logic [30:0] data, output logic rej);
    @(negedge clk);
    w_en = 1'b1; w_idx = idx; w_valid = v; w_asid = asid; w_vpn = vpn; w_data = data;
    @(negedge clk);
    w_en = 1'b0;
    rej = w_reject;
  endtask

  task automatic look(input logic [31:0] va);
    @(negedge clk);
    d_req = 1'b1; d_vaddr = va; i_req = 1'b1; i_vpn = va[31:10];
    @(negedge clk);
    d_req = 1'b0; i_req = 1'b0;
  endtask

  localparam logic [31:0] BASE = 32'h4560_0000;
  localparam logic [18:0] PPN  = 19'h5_A5C3;
  localparam logic [18:0] PPN2 = 19'h1_2345;

  initial begin
    logic rej;
    logic [21:0] vpn;
    vpn = BASE[31:10];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    chk("R7 reset done", d_done, 0);
    chk("R7 reset hit", {d_hit, i_hit, w_reject}, 0);
    // R1 empty array after reset
    look(32'h1234_5678);
    chk("R7 done after req", d_done, 1);
    chk("R1 miss after reset", {d_hit, d_multi, i_hit, i_multi}, 0);
    chk("R1 paddr zero", d_paddr, 0);

    // R5/R3 size sweep
    cur_asid = 8'd5;
    for (int sz = 0; sz < 4; sz++) begin
      wr(3'd2, 1'b1, 8'd5, vpn, mkdata(PPN, 2'(sz), 1'b0), rej);
      chk("R2 accepted write", rej, 0);
      for (int k = 0; k < 17; k++) begin
        logic [31:0] va;
        logic        eh;
        va = (k == 16) ? BASE + 32'h0010_0000 : BASE ^ (32'(k) * 32'h0000_9C45);
        eh = ((va[31:10] ^ vpn) & ~mask_of(2'(sz))) == 0;
        look(va);
        chk("R5 data hit", d_hit, eh);
        chk("R3 refill hit", i_hit, eh);
        chk("R5 paddr", d_paddr, eh ? exp_pa(PPN, 2'(sz), va) : 29'h0);
        chk("R10 entry word", d_entry, eh ? mkdata(PPN, 2'(sz), 1'b0) : 31'h0);
      end
    end

    // R3 ASID mismatch, then shared
    cur_asid = 8'd6;
    look(BASE);
    chk("R3 other asid misses", d_hit, 0);
    wr(3'd2, 1'b1, 8'd5, vpn, mkdata(PPN, 2'd1, 1'b1), rej);
    look(BASE + 32'h0C00);
    chk("R3 shared hits", d_hit, 1);
    chk("R3 shared paddr", d_paddr, exp_pa(PPN, 2'd1, BASE + 32'h0C00));

    // R4 single space mode ignores ASID
    wr(3'd2, 1'b1, 8'd5, vpn, mkdata(PPN, 2'd1, 1'b0), rej);
    svm_mode = 1'b1;
    look(BASE);
    chk("R4 svm hit", d_hit, 1);

    // R9 clash refused
    wr(3'd3, 1'b1, 8'd9, vpn, mkdata(PPN2, 2'd0, 1'b0), rej);
    chk("R9 reject flag", rej, 1);
    cur_asid = 8'd9;
    look(BASE);
    chk("R9 entry untouched (no multi)", {d_hit, d_multi}, 2'b10);
    chk("R9 paddr from old entry", d_paddr, exp_pa(PPN, 2'd1, BASE));
    wr(3'd3, 1'b1, 8'd9, vpn + 22'h100, mkdata(PPN2, 2'd0, 1'b0), rej);
    chk("R9 no clash accepted", rej, 0);

    // R6 multi hit
    svm_mode = 1'b0;
    wr(3'd3, 1'b1, 8'd9, vpn, mkdata(PPN2, 2'd0, 1'b1), rej);
    chk("R9 flag clear outside svm", rej, 0);
    cur_asid = 8'd5;
    look(BASE);
    chk("R6 data multi", {d_hit, d_multi}, 2'b01);
    chk("R6 paddr zero", d_paddr, 0);
    chk("R6 refill multi", {i_hit, i_multi}, 2'b01);
    chk("R6 refill tag zero", i_tag, 0);

    // R8 refill contents
    wr(3'd3, 1'b0, 8'd9, vpn, mkdata(PPN2, 2'd0, 1'b1), rej);
    look(BASE);
    chk("R8 refill hit", i_hit, 1);
    chk("R8 refill tag", i_tag, {8'd5, vpn, 1'b1});
    chk("R8 refill data", i_entry, mkdata(PPN, 2'd1, 1'b0));

    // R2 same-cycle write and lookup
    @(negedge clk);
    w_en = 1'b1; w_idx = 3'd4; w_valid = 1'b1; w_asid = 8'd5;
    w_vpn = 22'(32'h0ABC_D400 >> 10); w_data = mkdata(PPN2, 2'd0, 1'b0);
    d_req = 1'b1; d_vaddr = 32'h0ABC_D400;
    @(negedge clk);
    w_en = 1'b0; d_req = 1'b0;
    chk("R2 same cycle sees old", d_hit, 0);
    look(32'h0ABC_D7F0);
    chk("R2 next cycle sees new", d_hit, 1);
    chk("R2 new paddr", d_paddr, exp_pa(PPN2, 2'd0, 32'h0ABC_D7F0));

    // R1 flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    look(BASE);
    chk("R1 flush miss a", {d_hit, i_hit}, 0);
    look(32'h0ABC_D400);
    chk("R1 flush miss b", {d_hit, i_hit}, 0);

    // R7 idle cycle
    @(negedge clk);
    chk("R7 idle done low", {d_done, i_done}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule